// File: doc/BRIEF.md
# Inline Data Upload Engine

This block takes a stream of 32-bit words pushed by a host through a small register port and assembles them into a byte buffer of a programmed size. The size is the product of two configuration registers, a per-line byte length and a line count. Writing the execute register arms a transfer. Each data word adds its low-order bytes to the buffer, at most four and never more than the bytes still missing. The word flagged as the last one commits the buffer.

On commit in linear mode, the engine sends the buffered bytes one at a time to a byte-addressed memory write port with a valid/ready handshake. The bytes go to consecutive addresses starting at a 64-bit base, built from a high and a low address register. Non-linear (tiled) destinations are not supported. Committing such a transfer raises an error flag and writes nothing. A one-cycle completion pulse closes every commit.

Top module: `inline_upload`

## Requirements
- R1: After reset `memValid`, `done` and `unsupported` are all low.
- R2: A write to word 0x6C (execute) clears the fill offset and sets the transfer size to line length (word 0x60) times line count (word 0x61), saturated at `BUF_BYTES`. Bit 0 of the written value selects linear mode (1) or tiled mode (0). A later execute write restarts the fill.
- R3: Each write to word 0x6D (data) stores min(4, size − offset) bytes, taking byte 0 (bits 7:0) first, at the current offset, then advances the offset by that count. Once the size is reached, further bytes are discarded.
- R4: Memory writes start only after a data write with `regLast` high. The first byte is offered in the cycle after that write.
- R5: The base address is {word 0x62, word 0x63} (high word in bits 63:32), captured at commit. Buffer byte k goes to base + k, in ascending order of k.
- R6: While `memValid` is high and `memReady` is low, `memAddr` and `memData` hold and the engine does not advance.
- R7: `done` is high for exactly one cycle, in the cycle after the last byte is accepted, or in the cycle after the commit when nothing is written.
- R8: A commit in tiled mode performs no memory write and sets `unsupported`. The flag stays high until the next execute write.
- R9: Data writes made before any execute, or after a commit and before the next execute, cause no memory write and no `done`.
- R10: A commit with a transfer size of zero writes nothing and pulses `done`.
- R11: Execute and data writes made while bytes are being written out are ignored, and the ongoing output is unchanged.
- R12: Writes to word addresses other than 0x60–0x63, 0x6C and 0x6D have no effect, even with `regLast` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register word address |
| regWrData | input | DATA_W | Register write value |
| regLast | input | 1 | Marks a data write as the final word of the transfer |
| memValid | output | 1 | A byte is offered on the memory port |
| memReady | input | 1 | Memory accepts the offered byte |
| memAddr | output | 2*DATA_W | Byte address of the offered byte |
| memData | output | 8 | Offered byte |
| done | output | 1 | One-cycle pulse when a commit has finished |
| unsupported | output | 1 | The last commit requested a tiled destination |

## Verification
The assertions assume that the memory side behaves as a valid/ready sink, and that the host keeps the size and the number of words it pushes consistent, so that the fill never reaches beyond `BUF_BYTES`. The stimulus keeps every transfer at 64 bytes or fewer, saturating where it asks for more. It varies `memReady` between always high, alternating, and held low, so that the stall path is exercised. It issues register writes while a drain is in progress only to show that they are ignored.

// File: rtl/inline_upload_pkg.sv
package inline_upload_pkg;

  // word offsets decoded by the register front end
  localparam int OFF_LINE_LEN = 'h60;
  localparam int OFF_LINE_CNT = 'h61;
  localparam int OFF_ADDR_HI  = 'h62;
  localparam int OFF_ADDR_LO  = 'h63;
  localparam int OFF_EXEC     = 'h6C;
  localparam int OFF_DATA     = 'h6D;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_DRAIN,
    ST_DONE
  } upState_t;

  typedef struct packed {
    logic loadExec;
    logic packWord;
    logic startDrain;
    logic stepByte;
    logic setUnsup;
  } ctlStrobe_t;

endpackage

// File: rtl/inline_upload_dp.sv
module inline_upload_dp
  import inline_upload_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AW    = 12,
  parameter int BUF_BYTES = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  input  ctlStrobe_t            strobe,
  output logic                  execHit,
  output logic                  dataHit,
  output logic                  modeLinear,
  output logic                  sizeZero,
  output logic                  drainLast,
  output logic [2*DATA_W-1:0]   memAddr,
  output logic [7:0]            memData,
  output logic                  unsupported
);
  localparam int BPW    = DATA_W / 8;
  localparam int CNT_W  = $clog2(BUF_BYTES + 1);
  localparam int IDX_W  = $clog2(BUF_BYTES);
  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W-1:0] lineLen, lineCnt, addrHi, addrLo;
  logic [CNT_W-1:0]  copySize, wrOff, drainIdx;
  logic [ADDR_W-1:0] baseAddr;
  logic [7:0]        buffer [BUF_BYTES];

  logic [ADDR_W-1:0] prod;
  logic [CNT_W-1:0]  sizeNext, remain, take;

  assign execHit = regWrEn && (regAddr == REG_AW'(OFF_EXEC));
  assign dataHit = regWrEn && (regAddr == REG_AW'(OFF_DATA));

  // transfer size: product of the two geometry words, saturated at capacity
  assign prod     = {{DATA_W{1'b0}}, lineLen} * {{DATA_W{1'b0}}, lineCnt};
  assign sizeNext = (prod > ADDR_W'(BUF_BYTES)) ? CNT_W'(BUF_BYTES) : prod[CNT_W-1:0];
  assign remain   = copySize - wrOff;
  assign take     = (remain > CNT_W'(BPW)) ? CNT_W'(BPW) : remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineLen <= '0;
      lineCnt <= '0;
      addrHi  <= '0;
      addrLo  <= '0;
    end else if (regWrEn) begin
      if (regAddr == REG_AW'(OFF_LINE_LEN)) lineLen <= regWrData;
      if (regAddr == REG_AW'(OFF_LINE_CNT)) lineCnt <= regWrData;
      if (regAddr == REG_AW'(OFF_ADDR_HI))  addrHi  <= regWrData;
      if (regAddr == REG_AW'(OFF_ADDR_LO))  addrLo  <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      copySize    <= '0;
      wrOff       <= '0;
      modeLinear  <= 1'b0;
      unsupported <= 1'b0;
      baseAddr    <= '0;
      drainIdx    <= '0;
    end else begin
      if (strobe.loadExec) begin
        copySize    <= sizeNext;
        wrOff       <= '0;
        modeLinear  <= regWrData[0];
        unsupported <= 1'b0;
      end
      if (strobe.packWord)   wrOff <= wrOff + take;
      if (strobe.setUnsup)   unsupported <= 1'b1;
      if (strobe.startDrain) begin
        baseAddr <= {addrHi, addrLo};
        drainIdx <= '0;
      end
      if (strobe.stepByte)   drainIdx <= drainIdx + CNT_W'(1);
    end
  end

  // byte lanes of the incoming word land at consecutive buffer slots
  always_ff @(posedge clk) begin
    for (int lane = 0; lane < BPW; lane++) begin
      if (strobe.packWord && (CNT_W'(lane) < take))
        buffer[IDX_W'(wrOff + CNT_W'(lane))] <= regWrData[8*lane +: 8];
    end
  end

  assign sizeZero  = (copySize == '0);
  assign drainLast = (drainIdx == copySize - CNT_W'(1));
  assign memAddr   = baseAddr + ADDR_W'(drainIdx);
  assign memData   = buffer[drainIdx[IDX_W-1:0]];

endmodule

// File: rtl/inline_upload_ctl.sv
module inline_upload_ctl
  import inline_upload_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       execHit,
  input  logic       dataHit,
  input  logic       regLast,
  input  logic       modeLinear,
  input  logic       sizeZero,
  input  logic       drainLast,
  input  logic       memReady,
  output ctlStrobe_t strobe,
  output logic       memValid,
  output logic       done
);
  upState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        stateNext = ST_IDLE;
        if (execHit) begin
          strobe.loadExec = 1'b1;
          stateNext       = ST_FILL;
        end
      end
      ST_FILL: begin
        if (execHit) begin
          strobe.loadExec = 1'b1;
        end else if (dataHit) begin
          strobe.packWord = 1'b1;
          if (regLast) begin
            if (!modeLinear) begin
              strobe.setUnsup = 1'b1;
              stateNext       = ST_DONE;
            end else if (sizeZero) begin
              stateNext = ST_DONE;
            end else begin
              strobe.startDrain = 1'b1;
              stateNext         = ST_DRAIN;
            end
          end
        end
      end
      ST_DRAIN: begin
        if (memReady) begin
          if (drainLast) stateNext = ST_DONE;
          else           strobe.stepByte = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign memValid = (state == ST_DRAIN);
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/inline_upload.sv
module inline_upload
  import inline_upload_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AW    = 12,
  parameter int BUF_BYTES = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                regLast,
  output logic                memValid,
  input  logic                memReady,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [7:0]          memData,
  output logic                done,
  output logic                unsupported
);
  ctlStrobe_t strobe;
  logic execHit, dataHit, modeLinear, sizeZero, drainLast;

  inline_upload_dp #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .BUF_BYTES(BUF_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobe(strobe),
    .execHit(execHit), .dataHit(dataHit),
    .modeLinear(modeLinear), .sizeZero(sizeZero), .drainLast(drainLast),
    .memAddr(memAddr), .memData(memData), .unsupported(unsupported)
  );

  inline_upload_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .execHit(execHit), .dataHit(dataHit), .regLast(regLast),
    .modeLinear(modeLinear), .sizeZero(sizeZero), .drainLast(drainLast),
    .memReady(memReady),
    .strobe(strobe), .memValid(memValid), .done(done)
  );

endmodule

// File: rtl/inline_upload_chk.sv
module inline_upload_chk #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWrEn,
  input logic                regLast,
  input logic                memValid,
  input logic                memReady,
  input logic [2*DATA_W-1:0] memAddr,
  input logic [7:0]          memData,
  input logic                done,
  input logic                unsupported
);
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData));

  a_r5_addr_ascends: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memReady |=> !memValid || (memAddr == $past(memAddr) + 1'b1));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r7_done_not_during_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memValid);

  a_r8_no_write_when_unsup: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> !memValid);

  a_r4_write_follows_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memValid) |-> $past(regWrEn && regLast));

endmodule

bind inline_upload inline_upload_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regLast(regLast),
  .memValid(memValid), .memReady(memReady), .memAddr(memAddr),
  .memData(memData), .done(done), .unsupported(unsupported)
);

// File: tb/sim_inline_upload.sv
`timescale 1ns/1ps
module sim_inline_upload;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        regLast = 1'b0;
  logic        memValid, memReady, done, unsupported;
  logic [63:0] memAddr;
  logic [7:0]  memData;

  always #2.5 clk = ~clk;

  inline_upload u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regLast(regLast), .memValid(memValid),
    .memReady(memReady), .memAddr(memAddr), .memData(memData),
    .done(done), .unsupported(unsupported)
  );

  int testCnt = 0, failCnt = 0;
  int doneCnt = 0, expDone = 0;
  int readyMode = 0;
  int cyc = 0;
  logic [71:0] expQ[$];
  logic [71:0] pend[$];

  // bench model of the transfer being built
  int          tbSize, tbOff;
  bit          tbActive = 0, tbLinear;
  logic [31:0] tbHi, tbLo;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: drives ready, scores every accepted byte, counts done pulses
  always @(negedge clk) begin
    cyc++;
    case (readyMode)
      0: memReady = 1'b1;
      1: memReady = cyc[0];
      default: memReady = 1'b0;
    endcase
    if (rstN && memValid && memReady) begin
      if (expQ.size() == 0) begin
        check(0, "R9 unexpected write", memAddr, 0);
      end else begin
        logic [71:0] e;
        e = expQ.pop_front();
        check(memAddr == e[71:8] && memData == e[7:0], "R3/R5 byte",
              {memAddr[55:0], memData}, {e[63:8], e[7:0]});
      end
    end
    if (rstN && done) doneCnt++;
  end

  task automatic regWrite(input int addr, input logic [31:0] d, input logic last);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 12'(addr); regWrData = d; regLast = last;
    @(negedge clk);
    regWrEn = 1'b0; regLast = 1'b0;
  endtask

  task automatic startXfer(input int len, input int cnt, input logic [31:0] hi,
                           input logic [31:0] lo, input bit linear);
    longint p;
    regWrite('h60, 32'(len), 0);
    regWrite('h61, 32'(cnt), 0);
    regWrite('h62, hi, 0);
    regWrite('h63, lo, 0);
    p = longint'(len) * longint'(cnt);
    tbSize = (p > 64) ? 64 : int'(p);
    tbOff = 0; tbHi = hi; tbLo = lo; tbLinear = linear; tbActive = 1;
    pend.delete();
    regWrite('h6C, {31'b0, linear}, 0);
  endtask

  task automatic sendWord(input logic [31:0] d, input logic last);
    if (tbActive) begin
      int n;
      n = (tbSize - tbOff > 4) ? 4 : tbSize - tbOff;
      for (int i = 0; i < n; i++) pend.push_back({64'(tbOff + i), d[8*i +: 8]});
      tbOff += n;
      if (last) begin
        tbActive = 0;
        expDone++;
        if (tbLinear)
          foreach (pend[k]) expQ.push_back({{tbHi, tbLo} + pend[k][71:8], pend[k][7:0]});
        pend.delete();
      end
    end
    regWrite('h6D, d, last);
  endtask

  task automatic waitDone(input string tag);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      if (doneCnt == expDone && expQ.size() == 0) break;
    end
    repeat (3) @(negedge clk);
    #1;
    check(doneCnt == expDone, {tag, " done count"}, doneCnt, expDone);
    check(expQ.size() == 0, {tag, " bytes outstanding"}, expQ.size(), 0);
  endtask

  initial begin
    #400000;
    failCnt++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check(!memValid, "R1 memValid", memValid, 0);
    check(!done, "R1 done", done, 0);
    check(!unsupported, "R1 unsupported", unsupported, 0);
    rstN = 1'b1;

    // R9: data before any execute
    sendWord(32'hDEADBEEF, 1);
    repeat (10) @(negedge clk);
    #1;
    check(doneCnt == 0, "R9 data before exec", doneCnt, 0);

    // R2 R3 R4 R5: 3x3 = 9 bytes, the last word contributes one byte
    startXfer(3, 3, 32'h0000_0001, 32'h0000_0100, 1);
    sendWord(32'h44332211, 0);
    sendWord(32'h88776655, 0);
    sendWord(32'hCCBBAA99, 1);
    waitDone("R4 nine bytes");

    // R9: data after commit ignored
    sendWord(32'h12345678, 1);
    repeat (10) @(negedge clk);
    #1;
    check(doneCnt == expDone, "R9 data after commit", doneCnt, expDone);

    // R3: surplus words contribute nothing, alternating ready (R6)
    readyMode = 1;
    startXfer(2, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1);
    sendWord(32'hA1A2A3A4, 0);
    sendWord(32'hB1B2B3B4, 0);
    sendWord(32'hC1C2C3C4, 1);
    waitDone("R3 surplus words");
    readyMode = 0;

    // R2: a second execute restarts the fill
    startXfer(1, 5, 32'h0, 32'h2000, 1);
    sendWord(32'h0BADF00D, 0);
    tbOff = 0; pend.delete();
    regWrite('h6C, 32'h1, 0);
    sendWord(32'h04030201, 0);
    sendWord(32'h08070605, 1);
    waitDone("R2 restart");

    // R12: unmapped addresses ignored during fill
    startXfer(4, 1, 32'h0, 32'h3000, 1);
    regWrite('h64, 32'hFFFFFFFF, 0);
    regWrite('h6E, 32'hFFFFFFFF, 1);
    repeat (5) @(negedge clk);
    #1;
    check(doneCnt == expDone, "R12 unmapped write", doneCnt, expDone);
    sendWord(32'h5A5B5C5D, 1);
    waitDone("R12 transfer intact");

    // R8: tiled mode commits nothing and flags
    startXfer(4, 2, 32'h0, 32'h4000, 0);
    sendWord(32'h11111111, 0);
    sendWord(32'h22222222, 1);
    waitDone("R8 tiled");
    check(unsupported, "R8 flag set", unsupported, 1);
    startXfer(1, 1, 32'h0, 32'h4100, 1);
    #1;
    check(!unsupported, "R8 flag cleared by exec", unsupported, 0);
    sendWord(32'h000000EE, 1);
    waitDone("R8 recovery");

    // R10: zero size
    startXfer(0, 7, 32'h0, 32'h5000, 1);
    sendWord(32'hFFFFFFFF, 1);
    waitDone("R10 zero size");

    // R11 R6: exec and data during a stalled drain are ignored
    readyMode = 2;
    startXfer(8, 1, 32'h0, 32'h6000, 1);
    sendWord(32'h13121110, 0);
    sendWord(32'h17161514, 1);
    repeat (3) @(negedge clk);
    #1;
    check(memValid, "R6 valid held under stall", memValid, 1);
    regWrite('h6C, 32'h1, 0);
    regWrite('h6D, 32'h99999999, 1);
    readyMode = 0;
    waitDone("R11 drain untouched");

    // R2: saturation at buffer capacity
    startXfer(100, 1, 32'h7, 32'h0, 1);
    for (int w = 0; w < 17; w++) sendWord(32'(w * 32'h01010101 + 32'h03020100), w == 16);
    waitDone("R2 saturated size");

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule